// File: doc/BRIEF.md
# Johnson Decade Counter with Decoded Outputs

This block counts events modulo ten and presents the count as ten one-hot select lines plus a carry flag. The count is held in a five-stage twisted-ring register, which steps through ten codes that differ from their neighbours in a single bit. Each select line is formed from just two adjacent register bits. The carry flag is high for the first half of each ten-count cycle, so its rising edge marks the wrap from nine back to zero.

The count input and the inhibit input are ordinary data signals, not clocks. Both are brought onto the system clock through synchronizers, and their edges are found by comparing successive samples. The counter advances in two cases. The first is a rising edge of the count input while inhibit is low. The second is a falling edge of inhibit while the count input is high, which lets inhibit serve as an inverted count input. The carry of one counter can drive the count input of the next, so several counters chain into a decimal divider.

The clear input is active high. Asserting it forces count zero at once, without waiting for a clock. Its release passes through a synchronizer so that the release is clean.

Top module: `decade_ring_counter`

## Requirements
- R1: The count steps 0,1,...,9 and then wraps to 0. At count k exactly one select line is high, and it is `decOut[k]`, so `decOut` equals `1 << k`. The internal ring code is always one of the ten legal codes.
- R2: A rising edge on `countIn` while `inhibitIn` is low advances the count by one.
- R3: A falling edge on `inhibitIn` while `countIn` is high advances the count by one.
- R4: The count does not change in any of these cases: `countIn` edges while `inhibitIn` is held high, falling edges of `countIn`, rising edges of `inhibitIn`, and a falling edge of `inhibitIn` while `countIn` is low.
- R5: `carryOut` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R6: While `clearIn` is high, the outputs read count 0 (`decOut` = 10'b0000000001, `carryOut` = 1). This takes effect without waiting for a clock edge, and it overrides every edge on `countIn` or `inhibitIn`.
- R7: An input change applied between rising clock edges is acted on at the third rising edge that follows it. After `clearIn` falls, the earliest rising edge that can advance the count is the third one.
- R8: When the `carryOut` of one counter drives the `countIn` of a second counter, the second counter advances once for every ten counts of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state changes use its rising edge |
| clearIn | input | 1 | Active-high clear; asserts asynchronously, releases synchronously |
| countIn | input | 1 | Count input; its rising edge advances the count while inhibit is low |
| inhibitIn | input | 1 | High blocks counting; its falling edge counts while countIn is high |
| decOut | output | 2*STAGES (10) | One-hot decoded count; bit k is high at count k |
| carryOut | output | 1 | High for the first half of the cycle (counts 0 to 4) |

## Verification
Clear is due at once, so it is checked one time step after `clearIn` rises, before any clock edge. A count edge is due on the third rising clock edge after it is driven, and the first count after a release is due on the third rising edge after `clearIn` falls. The bench drives inputs just after falling edges. It keeps a model that ages the sampled inputs through the same number of edges, and it compares both chained counters against that model at every falling edge. It also places explicit checks on the cycle before and the cycle of the first post-release count, so an off-by-one in latency shows directly.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // Strobes from the input control to the ring datapath
  typedef struct packed {
    logic advance;   // step the ring by one code this cycle
    logic clearAct;  // synchronously released clear, asynchronously asserted
  } ctrl_strobe_t;

endpackage

// File: rtl/decade_sync.sv
module decade_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout,
  output logic doutPrev
);

  // chain[STAGES-1] is the synchronized sample, chain[STAGES] the one before
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-1:0], din};
  end

  assign dout     = chain[STAGES-1];
  assign doutPrev = chain[STAGES];

endmodule

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clearIn,
  input  logic         countIn,
  input  logic         inhibitIn,
  output ctrl_strobe_t strobe
);

  localparam int IDX_COUNT   = 0;
  localparam int IDX_INHIBIT = 1;
  localparam int NUM_IN      = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] nowV;
  logic [NUM_IN-1:0] prevV;

  assign rawIn[IDX_COUNT]   = countIn;
  assign rawIn[IDX_INHIBIT] = inhibitIn;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    decade_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .din      (rawIn[g]),
      .dout     (nowV[g]),
      .doutPrev (prevV[g])
    );
  end

  // Clear: asserted at once, released after SYNC_STAGES clock edges
  logic [SYNC_STAGES-1:0] rstPipe;

  always_ff @(posedge clk or posedge clearIn) begin
    if (clearIn) rstPipe <= '1;
    else         rstPipe <= {rstPipe[SYNC_STAGES-2:0], 1'b0};
  end

  logic cpNow, ceNow, cpRise, ceFall, clearAct;

  assign clearAct = rstPipe[SYNC_STAGES-1];
  assign cpNow    = nowV[IDX_COUNT];
  assign ceNow    = nowV[IDX_INHIBIT];
  assign cpRise   = nowV[IDX_COUNT] & ~prevV[IDX_COUNT];
  assign ceFall   = ~nowV[IDX_INHIBIT] & prevV[IDX_INHIBIT];

  assign strobe.clearAct = clearAct;
  assign strobe.advance  = ~clearAct & ((cpRise & ~ceNow) | (ceFall & cpNow));

  // R2 R3
  adv_edge_chk: assert property (@(posedge clk) disable iff (clearIn)
    strobe.advance |-> (cpNow && !ceNow && (!prevV[IDX_COUNT] || prevV[IDX_INHIBIT])));

  // R4
  no_count_cp_low_chk: assert property (@(posedge clk) disable iff (clearIn)
    (!cpNow || (ceNow && prevV[IDX_INHIBIT])) |-> !strobe.advance);

  // R6
  clear_blocks_chk: assert property (@(posedge clk)
    clearIn |-> !strobe.advance);

endmodule

// File: rtl/decade_path.sv
module decade_path
  import decade_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic                  clk,
  input  ctrl_strobe_t          strobe,
  output logic [2*STAGES-1:0]   decOut,
  output logic                  carryOut
);

  localparam int OUTS = 2 * STAGES;

  logic [STAGES-1:0] ring;
  logic              clearAct;
  logic              legal;

  assign clearAct = strobe.clearAct;

  // A legal twisted-ring code has at most one boundary between ones and zeros
  assign legal = ($countones(ring[STAGES-2:0] ^ ring[STAGES-1:1]) <= 1);

  always_ff @(posedge clk or posedge clearAct) begin
    if (clearAct)            ring <= '0;
    else if (!legal)         ring <= '0;
    else if (strobe.advance) ring <= {ring[STAGES-2:0], ~ring[STAGES-1]};
  end

  // Each select line looks at two neighbouring ring bits
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign decOut[k] = ~ring[STAGES-1] & ~ring[0];
    end else if (k < STAGES) begin : g_fill
      assign decOut[k] = ring[k-1] & ~ring[k];
    end else if (k == STAGES) begin : g_full
      assign decOut[k] = ring[STAGES-1] & ring[0];
    end else begin : g_drain
      assign decOut[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
    end
  end

  assign carryOut = ~ring[STAGES-1];

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (clearAct)
    legal);

  // R1
  one_hot_chk: assert property (@(posedge clk) disable iff (clearAct)
    $countones(decOut) == 1);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (clearAct)
    strobe.advance |=> decOut == {$past(decOut[OUTS-2:0]), $past(decOut[OUTS-1])});

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (clearAct)
    !strobe.advance |=> $stable(decOut));

  // R5
  carry_half_chk: assert property (@(posedge clk) disable iff (clearAct)
    carryOut == (|decOut[STAGES-1:0]));

  // R6
  clear_state_chk: assert property (@(posedge clk)
    clearAct |-> (decOut == OUTS'(1) && carryOut));

endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import decade_pkg::*;
#(
  parameter int STAGES      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                clearIn,
  input  logic                countIn,
  input  logic                inhibitIn,
  output logic [2*STAGES-1:0] decOut,
  output logic                carryOut
);

  ctrl_strobe_t strobe;

  decade_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .clearIn   (clearIn),
    .countIn   (countIn),
    .inhibitIn (inhibitIn),
    .strobe    (strobe)
  );

  decade_path #(.STAGES(STAGES)) u_path (
    .clk      (clk),
    .strobe   (strobe),
    .decOut   (decOut),
    .carryOut (carryOut)
  );

endmodule

// File: tb/decade_ring_counter_bench.sv
module decade_ring_counter_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       clearIn   = 1'b0;
  logic       countIn   = 1'b0;
  logic       inhibitIn = 1'b0;
  logic [9:0] decA, decB;
  logic       carA, carB;

  decade_ring_counter u_decade_ring_counter (
    .clk(clk), .clearIn(clearIn), .countIn(countIn), .inhibitIn(inhibitIn),
    .decOut(decA), .carryOut(carA)
  );

  // second stage of the chain, counted by the first stage's carry
  decade_ring_counter u_decade_ring_counter_b (
    .clk(clk), .clearIn(clearIn), .countIn(carA), .inhibitIn(1'b0),
    .decOut(decB), .carryOut(carB)
  );

  int    errors = 0;
  int    checks = 0;
  string phase  = "R6";
  bit    started = 0;
  bit    done    = 0;

  // behavioural model: input histories, count, release hold-off
  int   refCnt [2];
  int   relCnt [2];
  logic cpH    [2][4];
  logic ceH    [2][4];

  initial begin
    for (int m = 0; m < 2; m++) begin
      refCnt[m] = 0;
      relCnt[m] = 2;
      for (int i = 0; i < 4; i++) begin cpH[m][i] = 1'b0; ceH[m][i] = 1'b0; end
    end
  end

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      for (int i = 3; i > 0; i--) begin
        cpH[m][i] = cpH[m][i-1];
        ceH[m][i] = ceH[m][i-1];
      end
      cpH[m][0] = (m == 0) ? countIn : carA;
      ceH[m][0] = (m == 0) ? inhibitIn : 1'b0;
      if (clearIn) begin
        refCnt[m] = 0;
        relCnt[m] = 2;
      end else if (relCnt[m] > 0) begin
        relCnt[m] = relCnt[m] - 1;
      end else if ((cpH[m][2] && !cpH[m][3] && !ceH[m][2]) ||
                   (!ceH[m][2] && ceH[m][3] && cpH[m][2])) begin
        refCnt[m] = (refCnt[m] + 1) % 10;
      end
    end
    started = 1;
  end

  task automatic checkOut(input string tag, input logic [9:0] gotD,
                          input logic gotC, input int cnt);
    logic [9:0] expD;
    logic       expC;
    expD = 10'(1) << cnt;
    expC = (cnt < 5);
    checks++;
    if (gotD !== expD || gotC !== expC) begin
      errors++;
      $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
               tag, gotD, gotC, expD, expC);
    end
  endtask

  // per-cycle comparison of both stages against the model
  always @(negedge clk) begin
    if (started && !done) begin
      checkOut({phase, " stageA"}, decA, carA, refCnt[0]);
      checkOut({phase, " R8 stageB"}, decB, carB, refCnt[1]);
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseCp();
    countIn = 1'b1;
    settle(4);
    countIn = 1'b0;
    settle(4);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1 clearIn = 1'b1;
    settle(4);
    checkOut("R6 reset state", decA, carA, 0);
    clearIn = 1'b0;
    settle(4);

    // R7: count edge lands on the third rising edge
    phase = "R7";
    countIn = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    checkOut("R7 before third edge", decA, carA, 0);
    @(negedge clk); #1;
    checkOut("R7 at third edge", decA, carA, 1);
    countIn = 1'b0;
    settle(4);

    // R2 R1 R5: full cycle with wrap
    phase = "R2 R1 R5";
    repeat (11) pulseCp();
    checkOut("R2 after wrap", decA, carA, 2);

    // R4: inhibit held high blocks count edges
    phase = "R4";
    inhibitIn = 1'b1;
    settle(4);
    repeat (3) pulseCp();
    checkOut("R4 inhibited", decA, carA, 2);

    // R3: inhibit falling while count input high
    phase = "R3 R4";
    countIn = 1'b1;
    settle(4);
    repeat (4) begin
      inhibitIn = 1'b0;
      settle(4);
      inhibitIn = 1'b1;
      settle(4);
    end
    checkOut("R3 inhibit falls", decA, carA, 6);
    countIn = 1'b0;
    settle(4);
    inhibitIn = 1'b0;
    settle(4);
    checkOut("R4 inhibit fall with count low", decA, carA, 6);

    // R6: asynchronous clear overrides edges
    phase = "R6";
    clearIn = 1'b1;
    #1;
    checkOut("R6 async clear", decA, carA, 0);
    settle(1);
    repeat (2) pulseCp();
    checkOut("R6 clear overrides", decA, carA, 0);
    clearIn = 1'b0;
    settle(4);

    // R8: two-stage chain
    phase = "R8 R5";
    repeat (25) pulseCp();
    settle(4);
    checkOut("R8 first stage", decA, carA, 5);
    checkOut("R8 second stage", decB, carB, 2);

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired: actual=running expected=finished");
    finishRun();
  end

endmodule